// File: doc/BRIEF.md
# Power-Management Timer and Event Status Unit

This unit keeps a free-running power-management timer and three sticky status flags: timer overflow, firmware release (global), and bus-master activity. Software clears a flag by writing a one to its position in the status word. The overflow and global flags drive a combined event output. That output is steered to either a system control interrupt (SCI) or a system management interrupt (SMI) by the interrupt-mode input.

The timer counts one step for each cycle in which its clock enable is high. With the default 24-bit width, the overflow flag is set each time bit 22 goes from 0 to 1. At the nominal timer rate this happens about every 2.34 s.

Bus-master activity is gathered from the external request lines, an internal master request, a busy input, a C2-request message that arrives while the platform is in a deep C-state (C3 or C4), and DMA activity. This flag is for readback only and never raises an interrupt. A masking control can hide it from the readback, but a flag that DMA activity has set always shows.

Top module: `pm_evt_unit`

## Requirements
- R1: `tmr_o` resets to 0. It increases by one on each clock edge where `tick_i` is 1, holds when `tick_i` is 0, and wraps from all ones to 0.
- R2: The overflow flag (status bit 0) sets on the edge where timer bit `OVF_BIT` changes from 0 to 1. This bit is bit 22 for the default 24-bit timer.
- R3: When the overflow flag and `ovf_en_i` are both 1, `sci_o` is 1 if `sci_mode_i` is 1 and `smi_o` is 1 if `sci_mode_i` is 0. If `ovf_en_i` is 0, the overflow flag raises neither output.
- R4: A `bios_rel_i` pulse sets the global flag (status bit 1). While that flag is set, `sci_o` is 1 whatever the value of `sci_mode_i`.
- R5: The bus-master flag (status bit 2) sets when any `bus_req_i` line, `int_req_i`, `busy_i` or `dma_act_i` is 1. It also sets when `c2_msg_i` is 1 while `deep_c_i` is 1. A `c2_msg_i` pulse while `deep_c_i` is 0 does not set it.
- R6: The bus-master flag never drives `sci_o` or `smi_o`.
- R7: While `bm_mask_i` is 1, status bit 2 reads as 0, unless `dma_act_i` has been seen since the flag was last cleared. In that case it reads as 1.
- R8: A cycle with `wr_i`=1 clears each flag whose `wdata_i` bit is 1, using the positions overflow=0, global=1, bus-master=2. Flags whose `wdata_i` bit is 0 are left unchanged.
- R9: When a set event and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R10: After reset, all flags are 0 and `sci_o` and `smi_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer clock enable |
| bios_rel_i | input | 1 | Firmware release write pulse |
| bus_req_i | input | N_REQ | External bus request lines, active high |
| int_req_i | input | 1 | Internal master request |
| busy_i | input | 1 | Bus-master busy indication, active high |
| c2_msg_i | input | 1 | C2-request message pulse |
| deep_c_i | input | 1 | Platform is in C3 or C4 |
| dma_act_i | input | 1 | DMA activity |
| bm_mask_i | input | 1 | Force bus-master readback to 0 |
| sci_mode_i | input | 1 | 1 routes overflow events to SCI, 0 to SMI |
| ovf_en_i | input | 1 | Overflow event enable |
| wr_i | input | 1 | Status write strobe |
| wdata_i | input | 3 | Write-one-to-clear data |
| tmr_o | output | TMR_W | Timer value |
| sts_o | output | 3 | Status readback {bm, global, overflow} |
| sci_o | output | 1 | SCI request |
| smi_o | output | 1 | SMI request |

## Verification
The hardest case to reach is the masked bus-master readback that has to show 1 because DMA set the flag. The stimulus has to set the flag by DMA, keep the mask on across a clear, and then see a non-DMA source set the flag again while it still reads 0. A directed sequence walks through that order. Random cycles then mix DMA pulses, other request sources, the mask and clears.

The overflow edge normally takes millions of ticks to reach. The bench therefore uses a small timer width and runs the enable continuously through a full wrap. It checks both edges on which the overflow bit rises, under each interrupt mode.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int STS_W   = 3;
  localparam int OVF_IDX = 0;
  localparam int GLB_IDX = 1;
  localparam int BM_IDX  = 2;
endpackage

// File: rtl/pm_w1c_cell.sv
module pm_w1c_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= 1'b0;
    else if (set_i)   q_q <= 1'b1;
    else if (clr_i)   q_q <= 1'b0;
  end

  assign q_o = q_q;

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  p_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int TMR_W   = 24,
  parameter int OVF_BIT = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [TMR_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

  logic [TMR_W-1:0] cnt_q, cnt_nxt;

  assign cnt_nxt = cnt_q + ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_nxt;
  end

  // rising edge of the watched bit
  assign ovf_o = tick_i & cnt_nxt[OVF_BIT] & ~cnt_q[OVF_BIT];
  assign cnt_o = cnt_q;

  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (&cnt_q)) |=> (cnt_q == '0));
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (cnt_q == TMR_W'($past(cnt_q) + ONE)));
endmodule

// File: rtl/pm_bm_detect.sv
module pm_bm_detect #(
  parameter int N_REQ = 4
) (
  input  logic [N_REQ-1:0] bus_req_i,
  input  logic             int_req_i,
  input  logic             busy_i,
  input  logic             c2_msg_i,
  input  logic             deep_c_i,
  input  logic             dma_act_i,
  output logic             bm_set_o,
  output logic             dma_set_o
);
  logic c2_hit;

  assign c2_hit    = c2_msg_i & deep_c_i;
  assign bm_set_o  = (|bus_req_i) | int_req_i | busy_i | c2_hit | dma_act_i;
  assign dma_set_o = dma_act_i;
endmodule

// File: rtl/pm_evt_route.sv
module pm_evt_route (
  input  logic ovf_sts_i,
  input  logic glb_sts_i,
  input  logic ovf_en_i,
  input  logic sci_mode_i,
  output logic sci_o,
  output logic smi_o
);
  logic ovf_evt;

  assign ovf_evt = ovf_sts_i & ovf_en_i;
  assign sci_o   = (ovf_evt & sci_mode_i) | glb_sts_i;
  assign smi_o   = ovf_evt & ~sci_mode_i;
endmodule

// File: rtl/pm_evt_unit.sv
module pm_evt_unit
  import pm_evt_pkg::*;
#(
  parameter int TMR_W   = 24,
  parameter int OVF_BIT = 22,
  parameter int N_REQ   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             bios_rel_i,
  input  logic [N_REQ-1:0] bus_req_i,
  input  logic             int_req_i,
  input  logic             busy_i,
  input  logic             c2_msg_i,
  input  logic             deep_c_i,
  input  logic             dma_act_i,
  input  logic             bm_mask_i,
  input  logic             sci_mode_i,
  input  logic             ovf_en_i,
  input  logic             wr_i,
  input  logic [STS_W-1:0] wdata_i,
  output logic [TMR_W-1:0] tmr_o,
  output logic [STS_W-1:0] sts_o,
  output logic             sci_o,
  output logic             smi_o
);
  logic             ovf_set, bm_set, dma_set, dma_q;
  logic [STS_W-1:0] set_vec, clr_vec, sts_q;

  pm_timer #(.TMR_W(TMR_W), .OVF_BIT(OVF_BIT)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .cnt_o (tmr_o),
    .ovf_o (ovf_set)
  );

  pm_bm_detect #(.N_REQ(N_REQ)) u_bm (
    .bus_req_i(bus_req_i),
    .int_req_i(int_req_i),
    .busy_i   (busy_i),
    .c2_msg_i (c2_msg_i),
    .deep_c_i (deep_c_i),
    .dma_act_i(dma_act_i),
    .bm_set_o (bm_set),
    .dma_set_o(dma_set)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[OVF_IDX] = ovf_set;
    set_vec[GLB_IDX] = bios_rel_i;
    set_vec[BM_IDX]  = bm_set;
  end

  assign clr_vec = wdata_i & {STS_W{wr_i}};

  for (genvar i = 0; i < STS_W; i++) begin : g_sts
    pm_w1c_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_vec[i]),
      .clr_i (clr_vec[i]),
      .q_o   (sts_q[i])
    );
  end

  // remembers a DMA-caused set until the bus-master flag is cleared
  pm_w1c_cell u_dma (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (dma_set),
    .clr_i (clr_vec[BM_IDX]),
    .q_o   (dma_q)
  );

  always_comb begin
    sts_o         = sts_q;
    sts_o[BM_IDX] = sts_q[BM_IDX] & (~bm_mask_i | dma_q);
  end

  pm_evt_route u_route (
    .ovf_sts_i (sts_q[OVF_IDX]),
    .glb_sts_i (sts_q[GLB_IDX]),
    .ovf_en_i  (ovf_en_i),
    .sci_mode_i(sci_mode_i),
    .sci_o     (sci_o),
    .smi_o     (smi_o)
  );

  p_ovf_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmr_o[OVF_BIT]) |-> sts_o[OVF_IDX]);
  p_glb_sci_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_o[GLB_IDX] |-> sci_o);
  p_bm_silent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sts_o[GLB_IDX] && !(sts_o[OVF_IDX] && ovf_en_i)) |-> (!sci_o && !smi_o));
  p_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bm_mask_i && !dma_q) |-> !sts_o[BM_IDX]);
  p_smi_mode_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |-> (!sci_mode_i && ovf_en_i));
endmodule

// File: tb/pm_evt_unit_test.sv
module pm_evt_unit_test;
  localparam int TW = 10;
  localparam int OB = 8;
  localparam int NR = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick = 0, bios = 0, ireq = 0, busy = 0, c2 = 0, deep = 0, dma = 0;
  logic zro = 0, mode = 0, oen = 0, wr = 0;
  logic [NR-1:0] req = '0;
  logic [2:0] wdata = '0;
  logic [TW-1:0] tmr_o;
  logic [2:0] sts_o;
  logic sci_o, smi_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [TW-1:0] m_tmr = '0;
  logic m_ovf = 0, m_glb = 0, m_bm = 0, m_dma = 0;

  always #5 clk = ~clk;

  pm_evt_unit #(.TMR_W(TW), .OVF_BIT(OB), .N_REQ(NR)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .bios_rel_i(bios),
    .bus_req_i(req), .int_req_i(ireq), .busy_i(busy), .c2_msg_i(c2),
    .deep_c_i(deep), .dma_act_i(dma), .bm_mask_i(zro), .sci_mode_i(mode),
    .ovf_en_i(oen), .wr_i(wr), .wdata_i(wdata), .tmr_o(tmr_o),
    .sts_o(sts_o), .sci_o(sci_o), .smi_o(smi_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_sts();
    return {m_bm & (~zro | m_dma), m_glb, m_ovf};
  endfunction

  task automatic cmp_all();
    chk("R1 timer", 32'(tmr_o), 32'(m_tmr));
    chk("R8 status", 32'(sts_o), 32'(exp_sts()));
    chk("R3 sci", 32'(sci_o), 32'((m_ovf & oen & mode) | m_glb));
    chk("R3 smi", 32'(smi_o), 32'(m_ovf & oen & ~mode));
  endtask

  // advance one clock: update reference, clock, compare at negedge
  task automatic cyc();
    logic [TW-1:0] nx;
    logic so, sb;
    logic [2:0] clr;
    clr = wr ? wdata : 3'b000;
    nx  = tick ? m_tmr + TW'(1) : m_tmr;
    so  = tick && nx[OB] && !m_tmr[OB];
    sb  = (|req) | ireq | busy | (c2 & deep) | dma;
    m_ovf = so   ? 1'b1 : (clr[0] ? 1'b0 : m_ovf);
    m_glb = bios ? 1'b1 : (clr[1] ? 1'b0 : m_glb);
    m_bm  = sb   ? 1'b1 : (clr[2] ? 1'b0 : m_bm);
    m_dma = dma  ? 1'b1 : (clr[2] ? 1'b0 : m_dma);
    m_tmr = nx;
    @(posedge clk);
    @(negedge clk);
    cmp_all();
    bios = 0; c2 = 0; wr = 0; wdata = '0; dma = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 timer", 32'(tmr_o), 0);
    chk("R10 status", 32'(sts_o), 0);
    chk("R10 sci", 32'(sci_o), 0);
    chk("R10 smi", 32'(smi_o), 0);

    // R4 global flag raises sci in smi mode too
    bios = 1; cyc();
    chk("R4 glb set", 32'(sts_o[1]), 1);
    chk("R4 sci", 32'(sci_o), 1);
    // R8 writing zero to the global bit leaves it
    wr = 1; wdata = 3'b101; cyc();
    chk("R8 write0 keeps", 32'(sts_o[1]), 1);
    // R9 set beats clear
    bios = 1; wr = 1; wdata = 3'b010; cyc();
    chk("R9 set wins", 32'(sts_o[1]), 1);
    wr = 1; wdata = 3'b010; cyc();
    chk("R8 write1 clears", 32'(sts_o[1]), 0);
    chk("R8 sci drops", 32'(sci_o), 0);

    // R5 c2 message gated by deep C-state
    oen = 1; c2 = 1; deep = 0; cyc();
    chk("R5 c2 shallow ignored", 32'(sts_o[2]), 0);
    c2 = 1; deep = 1; cyc(); deep = 0;
    chk("R5 c2 deep sets", 32'(sts_o[2]), 1);
    chk("R6 no sci", 32'(sci_o), 0);
    chk("R6 no smi", 32'(smi_o), 0);

    // R7 mask hides non-DMA set, DMA set shows through
    zro = 1; #1;
    chk("R7 masked", 32'(sts_o[2]), 0);
    @(negedge clk);
    wr = 1; wdata = 3'b100; cyc();
    dma = 1; cyc();
    chk("R7 dma shows", 32'(sts_o[2]), 1);
    wr = 1; wdata = 3'b100; cyc();
    chk("R7 cleared", 32'(sts_o[2]), 0);
    busy = 1; cyc(); busy = 0;
    chk("R7 busy set masked", 32'(sts_o[2]), 0);
    zro = 0; #1;
    chk("R5 busy set", 32'(sts_o[2]), 1);
    @(negedge clk);
    wr = 1; wdata = 3'b100; cyc();

    // R2/R3 overflow edge and routing
    mode = 1; tick = 1;
    repeat (255) cyc();
    chk("R2 before edge", 32'(sts_o[0]), 0);
    cyc();
    chk("R2 edge sets", 32'(sts_o[0]), 1);
    chk("R1 count", 32'(tmr_o), 256);
    chk("R3 sci mode", 32'(sci_o), 1);
    tick = 0; mode = 0; #1;
    chk("R3 smi mode", 32'(smi_o), 1);
    chk("R3 smi mode sci", 32'(sci_o), 0);
    oen = 0; #1;
    chk("R3 disabled", 32'(smi_o), 0);
    @(negedge clk);
    wr = 1; wdata = 3'b001; cyc();
    tick = 1;
    for (int k = 0; k < 2000 && tmr_o != '1; k++) cyc();
    cyc();
    chk("R1 wrap", 32'(tmr_o), 0);
    chk("R2 second edge", 32'(sts_o[0]), 1);
    wr = 1; wdata = 3'b111; cyc();

    // random mix
    for (int i = 0; i < 6000; i++) begin
      tick  = 1'($urandom % 2);
      bios  = ($urandom % 32) == 0;
      req   = (($urandom % 16) == 0) ? NR'($urandom) : '0;
      ireq  = ($urandom % 32) == 0;
      busy  = ($urandom % 32) == 0;
      c2    = ($urandom % 8) == 0;
      deep  = ($urandom % 4) == 0;
      dma   = ($urandom % 48) == 0;
      zro   = ($urandom % 3) != 0;
      mode  = 1'($urandom % 2);
      oen   = 1'($urandom % 2);
      wr    = ($urandom % 4) == 0;
      wdata = 3'($urandom);
      cyc();
      req = '0; ireq = 0; busy = 0; deep = 0;
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule